// File: doc/BRIEF.md
# Store Queue with Youngest-Match Forwarding and Speculative Flush

The block is a circular buffer of address and data pairs, one pair per store, kept in program order. New stores are appended at the tail. Loads query the queue with an address. An associative search over every held entry returns the data of the youngest store with that address. If no entry has that address, the block reports a miss and the load reads data memory instead. The same address may be held in several entries at once.

A boundary pointer splits the held entries into two groups. The entries from the head up to the boundary are committed. The entries past the boundary are still speculative. Each retire request moves the boundary forward by one entry. Committed stores are not written to memory when they retire. They leave later, in order, through a drain port that presents the oldest entry whenever that entry is committed, and the head advances when memory accepts it. When a misspeculation occurs, a flush pulls the tail back to the boundary. This discards every speculative store, keeps every committed one, and frees those slots for the next enqueue.

Top module: `stq_fwd_queue`

## Requirements
- R1: After a synchronous active-low reset the queue holds no entries: `enq_ready` is 1, `ld_hit` is 0, `ld_data` is 0 and `mem_valid` is 0.
- R2: A store is accepted on a rising edge when `enq_valid` and `enq_ready` are both 1 and `flush` is 0. `enq_ready` is 0 exactly when DEPTH entries are held. A refused enqueue changes no held entry and no output.
- R3: `ld_hit` and `ld_data` are combinational from `ld_addr` and the held entries. When at least one held entry has address `ld_addr`, `ld_hit` is 1 and `ld_data` is the data of the most recently enqueued such entry.
- R4: When no held entry has address `ld_addr`, `ld_hit` is 0 and `ld_data` is 0. This holds for an empty queue.
- R5: A `retire_valid` pulse marks the oldest speculative entry as committed. When no speculative entry exists, the pulse is ignored. It is also ignored in a cycle with `flush`.
- R6: `mem_valid` is 1 exactly when the oldest held entry is committed. In that case `mem_addr` and `mem_data` carry that entry. `mem_ready` with `mem_valid` removes the entry on the edge. While `mem_ready` is 0, the outputs hold.
- R7: `flush` removes every speculative entry on the edge and keeps every committed entry. It takes priority over an enqueue and a retire in the same cycle. A later enqueue reuses the freed slots.
- R8: Lookup, drain order and fullness stay correct for any number of pointer wraparounds of the circular storage.
- R9: Committed entries that have not yet drained still take part in the lookup, alongside speculative ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Request to append a store |
| enq_addr | input | AW | Address of the appended store |
| enq_data | input | DW | Data of the appended store |
| enq_ready | output | 1 | Queue has a free slot |
| ld_addr | input | AW | Load query address |
| ld_hit | output | 1 | A held store matches the query |
| ld_data | output | DW | Data of the youngest matching store, 0 on a miss |
| retire_valid | input | 1 | Commit the oldest speculative store |
| flush | input | 1 | Discard all speculative stores |
| mem_valid | output | 1 | Oldest entry is committed and offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | AW | Address of the offered entry |
| mem_data | output | DW | Data of the offered entry |

## Verification
Three outputs respond in the same cycle as their inputs: the lookup result, `enq_ready` and the drain outputs are combinational from the current inputs and the stored state. Enqueue, retire, flush and drain show their effect only after the next rising edge, through a single register stage. The bench therefore drives every input on the falling edge and samples all outputs one time unit later. At the following rising edge it advances its own arithmetic model of the queue's head, boundary and tail, so each sample is compared against the state the design holds before that edge. A directed sequence covers duplicate addresses, a refused enqueue, retires with nothing left to commit, a flush that collides with an enqueue and a retire, and a stalled drain. It is followed by a long pseudo-random run on a four-entry queue with a four-address space, which wraps the pointers many times.

// File: rtl/stq_pkg.sv
// Shared types for the store queue.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package stq_pkg;

    // Operations the pointer control accepted in the current cycle.
    typedef struct packed {
        logic flush;   // cut the tail back to the commit boundary
        logic push;    // append one store at the tail
        logic retire;  // move the commit boundary forward by one
        logic pop;     // hand the head entry to memory
    } stq_ops_t;

endpackage

// File: rtl/stq_ptr_ctrl.sv
// Pointer control: keeps head, commit boundary and tail as wrap-extended
// counters and decides which requested operations are accepted.
// Assumes DEPTH is a power of two and PW = log2(DEPTH)+1, so the extra bit
// tells full from empty. Invariant kept: head <= boundary <= tail in
// circular distance from the head.
module stq_ptr_ctrl
    import stq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_valid,
    input  logic          retire_valid,
    input  logic          flush,
    input  logic          mem_ready,
    output logic [PW-1:0] head_q,
    output logic [PW-1:0] ret_q,
    output logic [PW-1:0] tail_q,
    output logic [PW-1:0] count,
    output logic          full,
    output stq_ops_t      ops
);

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    // Decode occupancy and accepted operations; flush takes priority.
    always_comb begin
        count      = tail_q - head_q;
        full       = (count == CAP);
        ops.flush  = flush;
        ops.push   = enq_valid && !full && !flush;
        ops.retire = retire_valid && (ret_q != tail_q) && !flush;
        ops.pop    = (ret_q != head_q) && mem_ready;
    end

    // Advance the three pointers on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            ret_q  <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PW'(ops.pop);
            ret_q  <= ret_q + PW'(ops.retire);
            tail_q <= ops.flush ? ret_q : tail_q + PW'(ops.push);
        end
    end

endmodule

// File: rtl/stq_slot_array.sv
// Slot storage: DEPTH address/data registers, one written per cycle.
// All slots are exposed in parallel for the associative search.
// Assumes the write index is already a slot index (pointer without wrap bit).
module stq_slot_array #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic [AW-1:0]              wr_addr,
    input  logic [DW-1:0]              wr_data,
    output logic [DEPTH-1:0][AW-1:0]   slot_addr,
    output logic [DEPTH-1:0][DW-1:0]   slot_data
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Capture the enqueued store into slot i when it is the tail slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[i] <= '0;
                slot_data[i] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                slot_addr[i] <= wr_addr;
                slot_data[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/stq_youngest_match.sv
// Associative search: walks the held entries from the head toward the
// tail in circular order and keeps the last match, i.e. the youngest.
// Assumes count <= DEPTH. Output data is zero on a miss.
module stq_youngest_match #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int PW    = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic [IW-1:0]            head_idx,
    input  logic [PW-1:0]            count,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [AW-1:0]            query,
    output logic                     hit,
    output logic [DW-1:0]            data
);

    // Scan by age so later (younger) matches override earlier ones.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if ((PW'(k) < count) &&
                (slot_addr[head_idx + IW'(k)] == query)) begin
                hit  = 1'b1;
                data = slot_data[head_idx + IW'(k)];
            end
        end
    end

endmodule

// File: rtl/stq_fwd_queue.sv
// Store queue top: program-ordered store buffer with youngest-match load
// forwarding, a commit boundary, in-order drain of committed stores and a
// flush of speculative stores back to the boundary.
// Assumes DEPTH is a power of two, at least 2. Lookup is combinational.
module stq_fwd_queue
    import stq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_valid,
    input  logic [AW-1:0] enq_addr,
    input  logic [DW-1:0] enq_data,
    output logic          enq_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          retire_valid,
    input  logic          flush,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);

    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0]            head_q, ret_q, tail_q, count;
    logic                     full;
    stq_ops_t                 ops;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;

    stq_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enq_valid    (enq_valid),
        .retire_valid (retire_valid),
        .flush        (flush),
        .mem_ready    (mem_ready),
        .head_q       (head_q),
        .ret_q        (ret_q),
        .tail_q       (tail_q),
        .count        (count),
        .full         (full),
        .ops          (ops)
    );

    stq_slot_array #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ops.push),
        .wr_idx    (tail_q[IW-1:0]),
        .wr_addr   (enq_addr),
        .wr_data   (enq_data),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    stq_youngest_match #(.DEPTH(DEPTH), .IW(IW), .PW(PW), .AW(AW), .DW(DW)) u_match (
        .head_idx  (head_q[IW-1:0]),
        .count     (count),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .query     (ld_addr),
        .hit       (ld_hit),
        .data      (ld_data)
    );

    // Edge outputs: free-slot flag and the head entry offered for drain.
    always_comb begin
        enq_ready = !full;
        mem_valid = (ret_q != head_q);
        mem_addr  = slot_addr[head_q[IW-1:0]];
        mem_data  = slot_data[head_q[IW-1:0]];
    end

endmodule

// File: rtl/stq_fwd_queue_chk.sv
// Checker for the store queue: pointer ordering, refused enqueue, flush
// target, drain stall and empty-queue lookup. Bound to the top below.
module stq_fwd_queue_chk #(
    parameter int DEPTH = 8,
    parameter int PW    = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] head_q,
    input logic [PW-1:0] ret_q,
    input logic [PW-1:0] tail_q,
    input logic          enq_valid,
    input logic          enq_ready,
    input logic          flush,
    input logic          ld_hit,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);

    logic [PW-1:0] held, committed;

    // Circular distances from the head.
    always_comb begin
        held      = tail_q - head_q;
        committed = ret_q - head_q;
    end

    // R2: never more than DEPTH entries held
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        held <= PW'(DEPTH));

    // R2: a refused enqueue leaves the tail where it was
    p_refused_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_ready && !flush) |=> (tail_q == $past(tail_q)));

    // R5: the commit boundary lies between head and tail
    p_boundary_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        committed <= held);

    // R7: flush cuts the tail back to the boundary
    p_flush_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tail_q == $past(ret_q)));

    // R6: a stalled drain keeps its offer steady
    p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R4: an empty queue never reports a hit
    p_empty_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (held == '0) |-> !ld_hit);

endmodule

bind stq_fwd_queue stq_fwd_queue_chk #(.DEPTH(DEPTH), .PW(PW), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_q    (head_q),
    .ret_q     (ret_q),
    .tail_q    (tail_q),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .flush     (flush),
    .ld_hit    (ld_hit),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
);

// File: tb/stq_fwd_queue_test.sv
// Bench for the store queue on a 4-entry, 4-bit address, 8-bit data
// configuration. An arithmetic model of head/boundary/tail predicts every
// output; inputs change on the falling edge, outputs are sampled 1 unit later.
module stq_fwd_queue_test;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam int AW     = 4;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enq_valid, retire_valid, flush, mem_ready;
    logic [AW-1:0] enq_addr, ld_addr;
    logic [DW-1:0] enq_data;
    logic          enq_ready, ld_hit, mem_valid;
    logic [DW-1:0] ld_data, mem_data;
    logic [AW-1:0] mem_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Model: absolute sequence numbers for head, boundary, tail.
    int            mh, mr, mt;
    logic [AW-1:0] ma [0:255];
    logic [DW-1:0] md [0:255];
    logic [DW-1:0] seq;

    always #(PERIOD/2) clk = ~clk;

    stq_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
        .clk (clk), .rst_n (rst_n),
        .enq_valid (enq_valid), .enq_addr (enq_addr), .enq_data (enq_data),
        .enq_ready (enq_ready),
        .ld_addr (ld_addr), .ld_hit (ld_hit), .ld_data (ld_data),
        .retire_valid (retire_valid), .flush (flush),
        .mem_valid (mem_valid), .mem_ready (mem_ready),
        .mem_addr (mem_addr), .mem_data (mem_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check against model state, then step the model.
    task automatic cyc(input logic ev, input logic [AW-1:0] ea, input logic rv,
                       input logic mrdy, input logic fl, input logic [AW-1:0] la,
                       input string tag);
        logic          eh;
        logic [DW-1:0] ed;
        int            ph, pr, pt;
        string         rq;
        enq_valid = ev; enq_addr = ea; enq_data = seq;
        retire_valid = rv; mem_ready = mrdy; flush = fl; ld_addr = la;
        #1;
        eh = 1'b0; ed = '0;
        for (int j = mh; j < mt; j++)
            if (ma[j % 256] == la) begin eh = 1'b1; ed = md[j % 256]; end
        rq = (tag != "") ? tag : "R2";
        chk(rq, "enq_ready", 32'(enq_ready), 32'(mt - mh < DEPTH));
        rq = (tag != "") ? tag : (eh ? "R3" : "R4");
        chk(rq, "ld_hit", 32'(ld_hit), 32'(eh));
        chk(rq, "ld_data", 32'(ld_data), 32'(ed));
        rq = (tag != "") ? tag : "R6";
        chk(rq, "mem_valid", 32'(mem_valid), 32'(mr > mh));
        if (mr > mh) begin
            chk(rq, "mem_addr", 32'(mem_addr), 32'(ma[mh % 256]));
            chk(rq, "mem_data", 32'(mem_data), 32'(md[mh % 256]));
        end
        @(posedge clk);
        ph = mh; pr = mr; pt = mt;
        if (pr > ph && mrdy) mh = ph + 1;
        if (fl) mt = pr;
        else begin
            if (ev && (pt - ph < DEPTH)) begin
                ma[pt % 256] = ea; md[pt % 256] = seq; mt = pt + 1;
            end
            if (rv && pr < pt) mr = pr + 1;
        end
        seq = seq + 8'd1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        mh = 0; mr = 0; mt = 0; seq = 8'h10;
        rst_n = 1'b0; enq_valid = 0; retire_valid = 0; flush = 0; mem_ready = 0;
        enq_addr = '0; enq_data = '0; ld_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        cyc(0, 0, 0, 1, 0, 4'd0, "R1");
        // R2: fill with duplicates of address 5, then a refused fifth store
        cyc(1, 4'd5, 0, 0, 0, 4'd5, "");
        cyc(1, 4'd3, 0, 0, 0, 4'd5, "");
        cyc(1, 4'd5, 0, 0, 0, 4'd5, "");
        cyc(1, 4'd5, 0, 0, 0, 4'd5, "");
        cyc(1, 4'd9, 0, 0, 0, 4'd9, "R2");
        cyc(0, 4'd0, 0, 0, 0, 4'd9, "R2");
        // R3 R4: sweep every query address over the full queue
        for (int a = 0; a < 16; a++) cyc(0, 0, 0, 0, 0, 4'(a), "");
        // R5: commit two entries
        cyc(0, 0, 1, 0, 0, 4'd5, "R5");
        cyc(0, 0, 1, 0, 0, 4'd3, "R5");
        // R7: flush colliding with an enqueue and a retire
        cyc(1, 4'd9, 1, 0, 1, 4'd5, "R7");
        cyc(0, 0, 0, 0, 0, 4'd9, "R7");
        // R9: committed undrained entry still forwards
        cyc(0, 0, 0, 0, 0, 4'd5, "R9");
        cyc(0, 0, 0, 0, 0, 4'd3, "R9");
        // R5: retire with nothing speculative is ignored
        cyc(0, 0, 1, 0, 0, 4'd5, "R5");
        cyc(1, 4'd7, 0, 0, 0, 4'd7, "R5");
        // R6: stalled drain, then drain both committed entries
        cyc(0, 0, 0, 0, 0, 4'd7, "R6");
        cyc(0, 0, 0, 1, 0, 4'd5, "R6");
        cyc(0, 0, 0, 1, 0, 4'd3, "R6");
        cyc(0, 0, 0, 1, 0, 4'd7, "R5");
        // R7: reused slots after flush
        cyc(0, 0, 0, 0, 1, 4'd7, "R7");
        cyc(1, 4'd7, 0, 0, 0, 4'd7, "R7");
        cyc(0, 0, 0, 0, 0, 4'd7, "R7");

        // R8: long pseudo-random run wrapping the pointers many times
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] | lf[1], {2'b00, lf[3:2]}, lf[4] & ~lf[9], lf[5] | lf[11],
                (lf[8:6] == 3'b111) && lf[12],
                {1'b0, lf[14] & lf[15], lf[11:10]},
                (n % 3 == 0) ? "R8" : "");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule